// File: doc/BRIEF.md
# Receive Descriptor Ring Walker

This block manages the receive side of a MAC's descriptor ring. The descriptors sit in a small on-chip memory inside the block. Software reaches that memory through a plain word-wide read/write port. Each descriptor is eight 32-bit words, so it spans 32 bytes. The hardware keeps a pointer to the current descriptor. When the receive datapath reports a finished frame with its length and error flags, the block checks the current descriptor's word 0.

If the empty flag is set, the hardware owns the descriptor. The block then writes the completion status into word 0, which clears the empty flag and so hands the descriptor to software. The pointer then moves on by one descriptor, or back to the ring base when the descriptor carries the wrap flag. Word 2 holds an interrupt-enable bit for each descriptor. A completion on a descriptor with that bit set gives a one-cycle receive interrupt, unless a global mask input suppresses it.

If the current descriptor is still owned by software, the block drops the frame, pulses a drop indication and stops. It stays stopped until software issues a poll demand, and then it continues from the same descriptor. Payload transfer, frames spread over several buffers and the transmit ring are handled elsewhere.

Top module: `rx_ring_walker`

## Requirements
- R1: After reset, `rx_active`, `rx_irq` and `frame_dropped` are 0 and every descriptor memory word reads 0.
- R2: A `poll_demand` while stopped makes `rx_active` 1 from the next cycle. The first poll after reset starts the walk at byte address `ring_base`, which must be 32-byte aligned.
- R3: A completion writes word 0 of the current descriptor with this layout:
  - bit 31: empty flag, cleared to 0;
  - bit 30: wrap flag, kept as it was;
  - bit 29: last-in-frame flag, set to 1;
  - bit 28: overlength;
  - bit 27: non-octet alignment;
  - bit 26: CRC error;
  - bit 25: overrun;
  - bit 24: truncated;
  - bits 15:0: length.

  Words 1 and 2 of the descriptor are not modified.
- R4: A frame longer than `cfg_max_buf` is stored with length `cfg_max_buf` and the truncated bit set. A frame exactly `cfg_max_buf` long is stored untruncated.
- R5: After a completion the pointer advances by 32 bytes. If the completed descriptor had the wrap flag, the pointer returns to `ring_base` instead, and descriptors beyond the wrap entry are never touched.
- R6: A frame that arrives while the current descriptor's empty flag is 0 is dropped. `frame_dropped` pulses in the next cycle, `rx_active` falls to 0 and the descriptor memory is unchanged.
- R7: A frame that arrives while stopped is dropped with a `frame_dropped` pulse and no memory change. A later poll resumes at the descriptor where the walk stopped.
- R8: `rx_irq` is high for exactly the cycle after a completion whose descriptor has word 2 bit 0 set while `irq_mask` is 0. It stays low otherwise.
- R9: The software port writes a word when `sw_we` is 1 and returns the addressed word on `sw_rdata` in the same cycle.
- R10: A `poll_demand` while `rx_active` is 1 has no effect on the walk position.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ring_base | input | ADDR_W | Byte address of the first descriptor |
| cfg_max_buf | input | LEN_W | Largest length stored without truncation |
| irq_mask | input | 1 | Suppresses `rx_irq` when 1 |
| poll_demand | input | 1 | Restart strobe from software |
| frame_done | input | 1 | One-cycle strobe: a frame has finished |
| frame_len | input | LEN_W | Length of the finished frame |
| err_long | input | 1 | Overlength status for the frame |
| err_align | input | 1 | Non-octet alignment status |
| err_crc | input | 1 | CRC error status |
| err_ovr | input | 1 | Receive FIFO overrun status |
| sw_we | input | 1 | Software write enable |
| sw_addr | input | WA_W | Software word address |
| sw_wdata | input | 32 | Software write data |
| sw_rdata | output | 32 | Software read data |
| rx_irq | output | 1 | Receive-frame interrupt pulse |
| frame_dropped | output | 1 | Dropped-frame pulse |
| rx_active | output | 1 | Walker is running (not stopped) |

## Verification
A wrong walk pointer shows up at the very next completion: the status lands in the wrong descriptor, which the software port reads back at once. A stuck run state shows up as a completion where a drop was due, or a drop where a completion was due, one cycle after the frame strobe. A bad interrupt qualifier shows up as `rx_irq` high or low in the single cycle after a completion. The bench therefore reads word 0 of the expected descriptor, and its neighbours, right after each frame.

// File: rtl/rxw_pkg.sv
package rxw_pkg;

   localparam int unsigned BIT_EMPTY = 31;
   localparam int unsigned BIT_WRAP  = 30;
   localparam int unsigned BIT_LAST  = 29;
   localparam int unsigned BIT_LONG  = 28;
   localparam int unsigned BIT_ALIGN = 27;
   localparam int unsigned BIT_CRC   = 26;
   localparam int unsigned BIT_OVR   = 25;
   localparam int unsigned BIT_TRUNC = 24;
   localparam int unsigned BIT_IRQEN = 0;

   typedef struct packed {
      logic too_long;
      logic misaligned;
      logic bad_crc;
      logic overrun;
   } rxw_err_t;

   typedef enum logic {
      WALK_STOPPED = 1'b0,
      WALK_RUNNING = 1'b1
   } rxw_state_e;

endpackage

// File: rtl/rxw_desc_mem.sv
module rxw_desc_mem #(
   parameter int unsigned WORDS     = 64,
   parameter int unsigned AW        = 6,
   parameter bit          SW_RD_REG = 1'b0
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          sw_we,
   input  logic [AW-1:0] sw_addr,
   input  logic [31:0]   sw_wdata,
   output logic [31:0]   sw_rdata,
   input  logic          hw_we,
   input  logic [AW-1:0] hw_waddr,
   input  logic [31:0]   hw_wdata,
   input  logic [AW-1:0] hw_raddr0,
   output logic [31:0]   hw_rdata0,
   input  logic [AW-1:0] hw_raddr2,
   output logic [31:0]   hw_rdata2
);

   logic [31:0] mem [WORDS];

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         for (int i = 0; i < WORDS; i++) mem[i] <= '0;
      end else begin
         if (sw_we) mem[sw_addr] <= sw_wdata;
         if (hw_we) mem[hw_waddr] <= hw_wdata;
      end
   end

   assign hw_rdata0 = mem[hw_raddr0];
   assign hw_rdata2 = mem[hw_raddr2];

   generate
      if (SW_RD_REG) begin : g_rd_reg
         logic [31:0] rd_q;
         always_ff @(posedge clk) begin
            if (!rst_n) rd_q <= '0;
            else        rd_q <= mem[sw_addr];
         end
         assign sw_rdata = rd_q;
      end else begin : g_rd_comb
         assign sw_rdata = mem[sw_addr];
      end
   endgenerate

endmodule

// File: rtl/rxw_ring_ptr.sv
module rxw_ring_ptr #(
   parameter int unsigned ADDR_W = 8,
   parameter int unsigned STRIDE = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              load_base,
   input  logic              advance,
   input  logic [ADDR_W-1:0] base,
   output logic [ADDR_W-1:0] ptr
);

   localparam logic [ADDR_W-1:0] STEP = ADDR_W'(STRIDE);

   always_ff @(posedge clk) begin
      if (!rst_n)         ptr <= '0;
      else if (load_base) ptr <= base;
      else if (advance)   ptr <= ptr + STEP;
   end

endmodule

// File: rtl/rxw_cmpl_fmt.sv
module rxw_cmpl_fmt
   import rxw_pkg::*;
#(
   parameter int unsigned LEN_W = 16
) (
   input  logic [LEN_W-1:0] len,
   input  logic [LEN_W-1:0] max_len,
   input  rxw_err_t         err,
   input  logic             wrap,
   output logic [31:0]      word
);

   logic             trunc;
   logic [LEN_W-1:0] len_eff;

   assign trunc   = (len > max_len);
   assign len_eff = trunc ? max_len : len;

   always_comb begin
      word             = '0;
      word[LEN_W-1:0]  = len_eff;
      word[BIT_EMPTY]  = 1'b0;
      word[BIT_WRAP]   = wrap;
      word[BIT_LAST]   = 1'b1;
      word[BIT_LONG]   = err.too_long;
      word[BIT_ALIGN]  = err.misaligned;
      word[BIT_CRC]    = err.bad_crc;
      word[BIT_OVR]    = err.overrun;
      word[BIT_TRUNC]  = trunc;
   end

endmodule

// File: rtl/rx_ring_walker.sv
module rx_ring_walker
   import rxw_pkg::*;
#(
   parameter int unsigned N_DESC     = 8,
   parameter int unsigned LEN_W      = 16,
   parameter bit          SW_RD_REG  = 1'b0,
   localparam int unsigned DESC_WORDS = 8,
   localparam int unsigned MEM_WORDS  = N_DESC * DESC_WORDS,
   localparam int unsigned WA_W       = $clog2(MEM_WORDS),
   localparam int unsigned ADDR_W     = WA_W + 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] ring_base,
   input  logic [LEN_W-1:0]  cfg_max_buf,
   input  logic              irq_mask,
   input  logic              poll_demand,
   input  logic              frame_done,
   input  logic [LEN_W-1:0]  frame_len,
   input  logic              err_long,
   input  logic              err_align,
   input  logic              err_crc,
   input  logic              err_ovr,
   input  logic              sw_we,
   input  logic [WA_W-1:0]   sw_addr,
   input  logic [31:0]       sw_wdata,
   output logic [31:0]       sw_rdata,
   output logic              rx_irq,
   output logic              frame_dropped,
   output logic              rx_active
);

   localparam int unsigned DW_W   = $clog2(DESC_WORDS);
   localparam int unsigned STRIDE = DESC_WORDS * 4;

   generate
      if (LEN_W < 8 || LEN_W > 24) begin : g_bad_len
         $error("rx_ring_walker: LEN_W must lie in 8..24");
      end
      if (N_DESC < 2 || (N_DESC & (N_DESC - 1)) != 0) begin : g_bad_depth
         $error("rx_ring_walker: N_DESC must be a power of two of at least 2");
      end
   endgenerate

   rxw_state_e        state_q;
   logic              fresh_q;
   logic [ADDR_W-1:0] ptr;
   logic [WA_W-1:0]   w0_addr, w2_addr;
   logic [31:0]       w0, w2, cmpl_word;
   logic              start, complete, stall, load_base, advance;
   logic              irq_q, drop_q;
   rxw_err_t          err;

   assign w0_addr = ptr[ADDR_W-1:2];
   assign w2_addr = {ptr[ADDR_W-1:2+DW_W], DW_W'(2)};
   assign err     = '{too_long: err_long, misaligned: err_align,
                      bad_crc: err_crc, overrun: err_ovr};

   assign start     = (state_q == WALK_STOPPED) && poll_demand;
   assign complete  = (state_q == WALK_RUNNING) && frame_done && w0[BIT_EMPTY];
   assign stall     = frame_done && !complete;
   assign load_base = (start && fresh_q) || (complete && w0[BIT_WRAP]);
   assign advance   = complete && !w0[BIT_WRAP];

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state_q <= WALK_STOPPED;
         fresh_q <= 1'b1;
         irq_q   <= 1'b0;
         drop_q  <= 1'b0;
      end else begin
         if (start) begin
            state_q <= WALK_RUNNING;
            fresh_q <= 1'b0;
         end else if (state_q == WALK_RUNNING && frame_done && !w0[BIT_EMPTY]) begin
            state_q <= WALK_STOPPED;
         end
         irq_q  <= complete && w2[BIT_IRQEN] && !irq_mask;
         drop_q <= stall;
      end
   end

   rxw_ring_ptr #(.ADDR_W(ADDR_W), .STRIDE(STRIDE)) i_ptr (
      .clk       (clk),
      .rst_n     (rst_n),
      .load_base (load_base),
      .advance   (advance),
      .base      (ring_base),
      .ptr       (ptr)
   );

   rxw_cmpl_fmt #(.LEN_W(LEN_W)) i_fmt (
      .len     (frame_len),
      .max_len (cfg_max_buf),
      .err     (err),
      .wrap    (w0[BIT_WRAP]),
      .word    (cmpl_word)
   );

   rxw_desc_mem #(.WORDS(MEM_WORDS), .AW(WA_W), .SW_RD_REG(SW_RD_REG)) i_mem (
      .clk       (clk),
      .rst_n     (rst_n),
      .sw_we     (sw_we),
      .sw_addr   (sw_addr),
      .sw_wdata  (sw_wdata),
      .sw_rdata  (sw_rdata),
      .hw_we     (complete),
      .hw_waddr  (w0_addr),
      .hw_wdata  (cmpl_word),
      .hw_raddr0 (w0_addr),
      .hw_rdata0 (w0),
      .hw_raddr2 (w2_addr),
      .hw_rdata2 (w2)
   );

   logic unused_bits;
   assign unused_bits = ^{w0[29:0], w2[31:1], ptr[1:0], ptr[2+DW_W-1:2]};

   assign rx_irq        = irq_q;
   assign frame_dropped = drop_q;
   assign rx_active     = (state_q == WALK_RUNNING);

endmodule

// File: rtl/rxw_checker.sv
module rxw_checker (
   input logic clk,
   input logic rst_n,
   input logic frame_done,
   input logic poll_demand,
   input logic irq_mask,
   input logic rx_irq,
   input logic frame_dropped,
   input logic rx_active
);

   a_r8_irq_needs_unmasked_frame: assert property (@(posedge clk) disable iff (!rst_n)
      rx_irq |-> ($past(frame_done) && !$past(irq_mask)));

   a_r6_drop_needs_frame: assert property (@(posedge clk) disable iff (!rst_n)
      frame_dropped |-> $past(frame_done));

   a_r2_poll_starts: assert property (@(posedge clk) disable iff (!rst_n)
      (poll_demand && !rx_active) |=> rx_active);

   a_r7_stopped_no_irq: assert property (@(posedge clk) disable iff (!rst_n)
      (frame_done && !rx_active) |=> (!rx_irq && frame_dropped));

   a_r8_irq_drop_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
      !(rx_irq && frame_dropped));

   a_r10_poll_keeps_running: assert property (@(posedge clk) disable iff (!rst_n)
      (rx_active && !frame_done) |=> rx_active);

endmodule

bind rx_ring_walker rxw_checker i_rxw_checker (
   .clk           (clk),
   .rst_n         (rst_n),
   .frame_done    (frame_done),
   .poll_demand   (poll_demand),
   .irq_mask      (irq_mask),
   .rx_irq        (rx_irq),
   .frame_dropped (frame_dropped),
   .rx_active     (rx_active)
);

// File: tb/test_rx_ring_walker.sv
`timescale 1ns/1ps
module test_rx_ring_walker;

   localparam int WA_W = 6;
   localparam int ADDR_W = 8;
   localparam int LEN_W = 16;
   localparam logic [31:0] E = 32'h8000_0000;
   localparam logic [31:0] W = 32'h4000_0000;
   localparam logic [15:0] MAXB = 16'd1536;

   // vector: [24] irq expected, [23:20] descriptor, [19:16] {long,align,crc,ovr}, [15:0] length
   localparam logic [31:0] VEC [3] = '{
      {7'd0, 1'b1, 4'd2, 4'b0000, 16'd100},
      {7'd0, 1'b0, 4'd3, 4'b0010, 16'd60},
      {7'd0, 1'b1, 4'd4, 4'b1000, 16'd1600}
   };

   logic clk = 0, rst_n = 0;
   logic [ADDR_W-1:0] ring_base = 8'd64;
   logic [LEN_W-1:0] cfg_max_buf = MAXB;
   logic irq_mask = 0, poll_demand = 0, frame_done = 0;
   logic [LEN_W-1:0] frame_len = 0;
   logic err_long = 0, err_align = 0, err_crc = 0, err_ovr = 0;
   logic sw_we = 0;
   logic [WA_W-1:0] sw_addr = 0;
   logic [31:0] sw_wdata = 0, sw_rdata;
   logic rx_irq, frame_dropped, rx_active;
   int nchk = 0, nfail = 0;

   always #2 clk = ~clk;

   rx_ring_walker i_rx_ring_walker (.*);

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      nchk++;
      if (act !== exp) begin
         nfail++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   function automatic logic [31:0] done_word(input logic [15:0] len, input logic [3:0] f,
                                             input logic wrap);
      logic tr;
      tr = len > MAXB;
      return {1'b0, wrap, 1'b1, f, tr, 8'h00, (tr ? MAXB : len)};
   endfunction

   task automatic rd(input int waddr, output logic [31:0] v);
      sw_addr = WA_W'(waddr);
      #0.5;
      v = sw_rdata;
   endtask

   task automatic wr(input int waddr, input logic [31:0] v);
      @(negedge clk);
      sw_we = 1; sw_addr = WA_W'(waddr); sw_wdata = v;
      @(negedge clk);
      sw_we = 0;
   endtask

   task automatic poll();
      @(negedge clk); poll_demand = 1;
      @(negedge clk); poll_demand = 0;
   endtask

   task automatic frame(input logic [15:0] len, input logic [3:0] f);
      @(negedge clk);
      frame_done = 1; frame_len = len;
      {err_long, err_align, err_crc, err_ovr} = f;
      @(negedge clk);
      frame_done = 0;
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      nfail++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("  End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
      $finish;
   end

   initial begin
      logic [31:0] v;
      repeat (3) @(negedge clk);
      rst_n = 1;
      @(negedge clk);
      check("R1 rx_active", {31'd0, rx_active}, 0);
      check("R1 rx_irq", {31'd0, rx_irq}, 0);
      check("R1 frame_dropped", {31'd0, frame_dropped}, 0);
      rd(16, v); check("R1 memory", v, 0);

      wr(16, E); wr(17, 32'h0000_1000); wr(18, 1);
      wr(24, E); wr(25, 32'h0000_2000); wr(26, 0);
      wr(32, E | W); wr(34, 1);
      wr(40, E);
      rd(17, v); check("R9 readback", v, 32'h0000_1000);

      frame(50, 0);
      check("R7 drop while stopped", {31'd0, frame_dropped}, 1);
      rd(16, v); check("R7 memory kept", v, E);

      poll();
      check("R2 active after poll", {31'd0, rx_active}, 1);

      for (int i = 0; i < 3; i++) begin
         frame(VEC[i][15:0], VEC[i][19:16]);
         check("R8 irq", {31'd0, rx_irq}, {31'd0, VEC[i][24]});
         check("R6 no drop", {31'd0, frame_dropped}, 0);
         rd(int'(VEC[i][23:20]) * 8, v);
         check("R3 R4 R5 status word", v,
               done_word(VEC[i][15:0], VEC[i][19:16], VEC[i][23:20] == 4'd4));
      end
      rd(17, v); check("R3 word1 kept", v, 32'h0000_1000);
      rd(18, v); check("R3 word2 kept", v, 1);

      // back at descriptor 2, which software still owns
      frame(70, 0);
      check("R6 drop pulse", {31'd0, frame_dropped}, 1);
      check("R6 stopped", {31'd0, rx_active}, 0);
      check("R6 no irq", {31'd0, rx_irq}, 0);
      rd(16, v); check("R6 memory kept", v, done_word(100, 0, 0));
      rd(40, v); check("R5 beyond wrap untouched", v, E);

      wr(16, E); wr(24, E);
      irq_mask = 1;
      frame(80, 0);
      check("R7 drop while stopped again", {31'd0, frame_dropped}, 1);
      rd(16, v); check("R7 memory kept again", v, E);
      poll();
      poll();
      check("R10 still active", {31'd0, rx_active}, 1);
      frame(MAXB, 0);
      check("R8 masked irq", {31'd0, rx_irq}, 0);
      rd(16, v); check("R4 R7 R10 boundary at resume point", v, done_word(MAXB, 0, 0));

      irq_mask = 0;
      frame(MAXB + 16'd1, 4'b0101);
      check("R8 irq disabled by word2", {31'd0, rx_irq}, 0);
      rd(24, v); check("R4 truncated by one", v, done_word(MAXB + 16'd1, 4'b0101, 0));

      frame(90, 0);
      check("R6 drop on owned desc", {31'd0, frame_dropped}, 1);
      rd(32, v); check("R6 wrap desc kept", v, done_word(1600, 4'b1000, 1));

      $display("  End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
      $finish;
   end

endmodule